// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between an 8-bit processor bus and the address lines of an external ROM and RAM. The processor has a 16-bit address space. A write into the ROM window goes to no memory. It is decoded instead as an update to one of three control fields: a 5-bit low ROM bank number, a 2-bit upper field and a 1-bit banking mode. A read of the ROM window, or a read or write of the external RAM window, produces a registered physical address and a chip-select for the memory being accessed.

The lower 16 KiB of ROM space always shows bank 0. The upper 16 KiB shows a switchable bank. The 2-bit upper field is shared, and the mode bit decides its use. In mode 0 it supplies bits 6:5 of the ROM bank number. In mode 1 it selects one of four 8 KiB RAM banks. A low bank value of zero can never be selected, because zero is replaced by one. The ROM and RAM arrays themselves, and any RAM enable gating, lie outside this block.

Top module: `cart_bank_map`

## Requirements
- R1: After reset the low bank is 1, the upper field is 0 and the mode is 0. Both chip-selects and both address outputs are 0, a read of 0x4000 maps to ROM address 0x4000, and a read of 0xA010 maps to RAM address 0x0010.
- R2: A read of 0x0000–0x3FFF asserts rom_cs and gives rom_addr equal to the CPU address, whatever the bank registers hold.
- R3: A read of 0x4000–0x7FFF asserts rom_cs with rom_addr = bank × 0x4000 + (address − 0x4000).
- R4: A write to 0x2000–0x3FFF loads data bits 4:0 into the low bank. Data bits 7:5 are ignored and the upper field is not changed.
- R5: If a write to 0x2000–0x3FFF carries zero in data bits 4:0, the low bank becomes 1. With the upper field at 0, 1, 2 or 3 in mode 0, this gives bank 0x01, 0x21, 0x41 or 0x61.
- R6: A write to 0x4000–0x5FFF loads data bits 1:0 into the upper field.
- R7: A write to 0x6000–0x7FFF loads data bit 0 into the mode bit (0 = ROM banking, 1 = RAM banking).
- R8: In mode 0 the ROM bank is (upper × 32) + low, and a RAM access at 0xA000–0xBFFF maps to address − 0xA000 (RAM bank 0).
- R9: In mode 1 the ROM bank is the low bank alone. A RAM access maps to upper × 0x2000 + (address − 0xA000).
- R10: rom_cs and ram_cs are never both high. rom_cs is high only in the cycle after a read of 0x0000–0x7FFF, and ram_cs only in the cycle after a read or write of 0xA000–0xBFFF. In every other cycle both are 0 and the address outputs keep their last values. A register write takes effect for the access in the next cycle.
- R11: A write to 0x0000–0x1FFF changes none of the mapping state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| rom_addr | output | ROM_AW (21) | Registered ROM physical address |
| ram_addr | output | 15 | Registered RAM physical address |
| rom_cs | output | 1 | ROM access in progress (registered) |
| ram_cs | output | 1 | RAM access in progress (registered) |

## Verification
Every access result is due exactly one clock after its strobe cycle, because one register stage follows the combinational map. A control write changes the mapping for a strobe in the very next cycle. The driver therefore pushes one expected item for each cycle it drives, using a bench model updated after that cycle's expectation is formed. The monitor pops one item one nanosecond after each following rising edge. Idle, out-of-window and register-write cycles push items too, with both selects low and the addresses held, so a select that fires late, early or spuriously is caught.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;

  localparam int CPU_AW      = 16;
  localparam int LOW_W       = 5;
  localparam int HI_W        = 2;
  localparam int FULL_BANK_W = LOW_W + HI_W;
  localparam int ROM_OFF_W   = 14;
  localparam int RAM_OFF_W   = 13;
  localparam int ROM_FULL_W  = FULL_BANK_W + ROM_OFF_W;
  localparam int RAM_AW      = HI_W + RAM_OFF_W;

  typedef enum logic [1:0] {
    RGN_FIXED  = 2'd0,
    RGN_SWITCH = 2'd1,
    RGN_XRAM   = 2'd2,
    RGN_OTHER  = 2'd3
  } cbm_region_e;

  typedef enum logic [2:0] {
    WSEL_NONE   = 3'd0,
    WSEL_ENABLE = 3'd1,
    WSEL_LOW    = 3'd2,
    WSEL_UPPER  = 3'd3,
    WSEL_MODE   = 3'd4
  } cbm_wsel_e;

  // Top three address bits pick an 8 KiB slice of the bus.
  function automatic cbm_region_e region_of(input logic [2:0] slice);
    case (slice)
      3'b000, 3'b001: region_of = RGN_FIXED;
      3'b010, 3'b011: region_of = RGN_SWITCH;
      3'b101:         region_of = RGN_XRAM;
      default:        region_of = RGN_OTHER;
    endcase
  endfunction

  function automatic cbm_wsel_e wsel_of(input logic [2:0] slice);
    case (slice)
      3'b000:  wsel_of = WSEL_ENABLE;
      3'b001:  wsel_of = WSEL_LOW;
      3'b010:  wsel_of = WSEL_UPPER;
      3'b011:  wsel_of = WSEL_MODE;
      default: wsel_of = WSEL_NONE;
    endcase
  endfunction

  // Zero cannot be selected as a low bank.
  function automatic logic [LOW_W-1:0] fix_low(input logic [LOW_W-1:0] v);
    fix_low = (v == '0) ? LOW_W'(1) : v;
  endfunction

  function automatic logic [FULL_BANK_W-1:0] rom_bank_sel(
      input logic [LOW_W-1:0] low, input logic [HI_W-1:0] upper, input logic mode);
    rom_bank_sel = mode ? {{HI_W{1'b0}}, low} : {upper, low};
  endfunction

  function automatic logic [ROM_FULL_W-1:0] rom_phys(
      input logic switched, input logic [FULL_BANK_W-1:0] bank,
      input logic [ROM_OFF_W-1:0] off);
    rom_phys = switched ? {bank, off} : {{FULL_BANK_W{1'b0}}, off};
  endfunction

  function automatic logic [RAM_AW-1:0] ram_phys(
      input logic [HI_W-1:0] upper, input logic mode, input logic [RAM_OFF_W-1:0] off);
    ram_phys = {(mode ? upper : {HI_W{1'b0}}), off};
  endfunction

endpackage

// File: rtl/cbm_decode.sv
`timescale 1ns/1ps
module cbm_decode
  import cbm_pkg::*;
(
  input  logic [2:0]  addr_slice,
  input  logic        rd,
  input  logic        wr,
  output cbm_region_e region,
  output cbm_wsel_e   wsel,
  output logic        rom_hit,
  output logic        ram_hit
);

  always_comb begin
    region  = region_of(addr_slice);
    wsel    = wr ? wsel_of(addr_slice) : WSEL_NONE;
    rom_hit = rd && ((region == RGN_FIXED) || (region == RGN_SWITCH));
    ram_hit = (rd || wr) && (region == RGN_XRAM);
  end

endmodule

// File: rtl/cbm_regs.sv
`timescale 1ns/1ps
module cbm_regs
  import cbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cbm_wsel_e        wsel,
  input  logic [LOW_W-1:0] wdata_low,
  output logic [LOW_W-1:0] low_bank,
  output logic [HI_W-1:0]  hi_field,
  output logic             bank_mode
);

  logic [LOW_W-1:0] low_next;
  logic [HI_W-1:0]  hi_next;
  logic             mode_next;

  always_comb begin
    low_next  = low_bank;
    hi_next   = hi_field;
    mode_next = bank_mode;
    case (wsel)
      WSEL_LOW:   low_next  = fix_low(wdata_low);
      WSEL_UPPER: hi_next   = wdata_low[HI_W-1:0];
      WSEL_MODE:  mode_next = wdata_low[0];
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_bank  <= LOW_W'(1);
      hi_field  <= '0;
      bank_mode <= 1'b0;
    end else begin
      low_bank  <= low_next;
      hi_field  <= hi_next;
      bank_mode <= mode_next;
    end
  end

endmodule

// File: rtl/cbm_map.sv
`timescale 1ns/1ps
module cbm_map
  import cbm_pkg::*;
(
  input  cbm_region_e          region,
  input  logic [ROM_OFF_W-1:0] offset,
  input  logic [LOW_W-1:0]     low_bank,
  input  logic [HI_W-1:0]      hi_field,
  input  logic                 bank_mode,
  output logic [ROM_FULL_W-1:0] rom_full,
  output logic [RAM_AW-1:0]    ram_full
);

  logic [FULL_BANK_W-1:0] bank;

  always_comb begin
    bank     = rom_bank_sel(low_bank, hi_field, bank_mode);
    rom_full = rom_phys(region == RGN_SWITCH, bank, offset);
    ram_full = ram_phys(hi_field, bank_mode, offset[RAM_OFF_W-1:0]);
  end

endmodule

// File: rtl/cart_bank_map.sv
`timescale 1ns/1ps
module cart_bank_map
  import cbm_pkg::*;
#(
  parameter int ROM_AW = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [14:0]       ram_addr,
  output logic              rom_cs,
  output logic              ram_cs
);

  localparam int ROM_KEEP = (ROM_AW < ROM_FULL_W) ? ROM_AW : ROM_FULL_W;

  cbm_region_e            region;
  cbm_wsel_e              wsel;
  logic                   rom_hit;
  logic                   ram_hit;
  logic [LOW_W-1:0]       low_bank;
  logic [HI_W-1:0]        hi_field;
  logic                   bank_mode;
  logic [ROM_FULL_W-1:0]  rom_full;
  logic [RAM_AW-1:0]      ram_full;
  logic [ROM_AW-1:0]      rom_next;
  logic                   unused_wdata;

  assign unused_wdata = ^cpu_wdata[7:LOW_W];

  cbm_decode u_decode (
    .addr_slice (cpu_addr[15:13]),
    .rd         (cpu_rd),
    .wr         (cpu_wr),
    .region     (region),
    .wsel       (wsel),
    .rom_hit    (rom_hit),
    .ram_hit    (ram_hit)
  );

  cbm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wsel      (wsel),
    .wdata_low (cpu_wdata[LOW_W-1:0]),
    .low_bank  (low_bank),
    .hi_field  (hi_field),
    .bank_mode (bank_mode)
  );

  cbm_map u_map (
    .region    (region),
    .offset    (cpu_addr[ROM_OFF_W-1:0]),
    .low_bank  (low_bank),
    .hi_field  (hi_field),
    .bank_mode (bank_mode),
    .rom_full  (rom_full),
    .ram_full  (ram_full)
  );

  // Fit the full-width ROM address to the port width.
  generate
    if (ROM_AW > ROM_FULL_W) begin : g_rom_pad
      assign rom_next = {{(ROM_AW-ROM_FULL_W){1'b0}}, rom_full};
    end else begin : g_rom_trim
      logic unused_rom_hi;
      assign rom_next      = rom_full[ROM_KEEP-1:0];
      assign unused_rom_hi = ^rom_full;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_cs   <= 1'b0;
      ram_cs   <= 1'b0;
      rom_addr <= '0;
      ram_addr <= '0;
    end else begin
      rom_cs <= rom_hit;
      ram_cs <= ram_hit;
      if (rom_hit) rom_addr <= rom_next;
      if (ram_hit) ram_addr <= ram_full;
    end
  end

endmodule

// File: rtl/cbm_checks.sv
`timescale 1ns/1ps
module cbm_checks #(
  parameter int ROM_AW = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [14:0]       ram_addr,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic [4:0]        low_bank,
  input logic [1:0]        hi_field,
  input logic              bank_mode
);

  logic unused_chk;
  assign unused_chk = ^{cpu_wdata[7:5], ram_addr[12:0]};

  p_cs_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));

  p_low_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    low_bank != 5'd0);

  p_fixed_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:14] == 2'b00) |=>
      (rom_cs && rom_addr == ROM_AW'($past(cpu_addr))));

  p_low_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_wdata[4:0] != 5'd0) |=>
      (low_bank == $past(cpu_wdata[4:0]) && $stable(hi_field)));

  p_upper_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b010) |=> (hi_field == $past(cpu_wdata[1:0])));

  p_mode_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=> (bank_mode == $past(cpu_wdata[0])));

  p_mode0_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:13] == 3'b101 && !bank_mode) |=>
      (ram_cs && ram_addr[14:13] == 2'b00));

  p_mode1_ram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:13] == 3'b101 && bank_mode) |=>
      (ram_cs && ram_addr[14:13] == $past(hi_field)));

  p_enable_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000) |=>
      ($stable(low_bank) && $stable(hi_field) && $stable(bank_mode)));

endmodule

bind cart_bank_map cbm_checks #(.ROM_AW(ROM_AW)) u_cbm_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_wr    (cpu_wr),
  .cpu_rd    (cpu_rd),
  .rom_addr  (rom_addr),
  .ram_addr  (ram_addr),
  .rom_cs    (rom_cs),
  .ram_cs    (ram_cs),
  .low_bank  (low_bank),
  .hi_field  (hi_field),
  .bank_mode (bank_mode)
);

// File: tb/test_cart_bank_map.sv
`timescale 1ns/1ps
module test_cart_bank_map;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_cs;
  logic        ram_cs;

  always #2.5 clk = ~clk;

  cart_bank_map i_cart_bank_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs)
  );

  typedef struct {
    logic        rc;
    logic        mc;
    logic [20:0] ra;
    logic [14:0] ma;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  // Bench model of the mapping state.
  int          m_low = 1;
  int          m_hi = 0;
  int          m_mode = 0;
  logic [20:0] m_ra = '0;
  logic [14:0] m_ma = '0;

  task automatic cyc(input logic [15:0] a, input logic [7:0] d,
                     input logic w, input logic r, input string tag);
    exp_t e;
    int   bank;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = r;
    e.rc = 1'b0; e.mc = 1'b0; e.tag = tag;
    if (r && a < 16'h8000) begin
      e.rc = 1'b1;
      if (a < 16'h4000) m_ra = 21'(a);
      else begin
        bank = (m_mode == 1) ? m_low : (m_hi * 32 + m_low);
        m_ra = 21'(bank * 16384 + (int'(a) - 16'h4000));
      end
    end
    if ((r || w) && a >= 16'hA000 && a < 16'hC000) begin
      e.mc = 1'b1;
      m_ma = 15'(((m_mode == 1) ? m_hi : 0) * 8192 + (int'(a) - 16'hA000));
    end
    e.ra = m_ra; e.ma = m_ma;
    q.push_back(e);
    if (w) begin
      if (a >= 16'h2000 && a < 16'h4000) m_low = (int'(d) % 32 == 0) ? 1 : int'(d) % 32;
      else if (a >= 16'h4000 && a < 16'h6000) m_hi = int'(d) % 4;
      else if (a >= 16'h6000 && a < 16'h8000) m_mode = int'(d) % 2;
    end
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    cyc(a, 8'h00, 1'b0, 1'b1, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    cyc(a, d, 1'b1, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(16'h0000, 8'h00, 1'b0, 1'b0, tag);
  endtask

  // Monitor: one expected item per driven cycle, due one clock later.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (rom_cs !== e.rc || ram_cs !== e.mc || rom_addr !== e.ra || ram_addr !== e.ma) begin
          n_bad++;
          $display("FAIL %s: actual rom_cs=%0b ram_cs=%0b rom=%06h ram=%04h expected rom_cs=%0b ram_cs=%0b rom=%06h ram=%04h",
                   e.tag, rom_cs, ram_cs, rom_addr, ram_addr, e.rc, e.mc, e.ra, e.ma);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10: watchdog actual=running expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    n_chk++;  // R1 reset state
    if (rom_cs !== 1'b0 || ram_cs !== 1'b0 || rom_addr !== '0 || ram_addr !== '0) begin
      n_bad++;
      $display("FAIL R1: actual cs=%0b%0b rom=%06h ram=%04h expected cs=00 rom=000000 ram=0000",
               rom_cs, ram_cs, rom_addr, ram_addr);
    end

    rd(16'h4000, "R1");
    rd(16'hA010, "R1");
    rd(16'h0000, "R2");
    rd(16'h1234, "R2");
    rd(16'h3FFF, "R2");
    wr(16'h2100, 8'h05, "R4");
    rd(16'h4ABC, "R3");
    wr(16'h2000, 8'hE3, "R4");
    rd(16'h6001, "R4");
    wr(16'h3FFF, 8'h00, "R5");
    rd(16'h4002, "R5");
    wr(16'h4000, 8'hFE, "R6");
    wr(16'h2000, 8'h20, "R5");
    rd(16'h5555, "R5");
    rd(16'hA123, "R8");
    wr(16'h5FFF, 8'h01, "R6");
    rd(16'h4010, "R8");
    wr(16'h2000, 8'h1F, "R4");
    wr(16'h4000, 8'h03, "R6");
    rd(16'h7FFF, "R8");
    rd(16'hBFFF, "R8");
    wr(16'h6000, 8'h03, "R7");
    rd(16'h7FFF, "R9");
    rd(16'hBFFF, "R9");
    wr(16'hA001, 8'h55, "R9");
    rd(16'h0100, "R2");
    wr(16'h4000, 8'h01, "R6");
    rd(16'hA800, "R9");
    wr(16'h7000, 8'hFE, "R7");
    rd(16'hA800, "R7");
    rd(16'h4000, "R7");
    wr(16'h1000, 8'h0A, "R11");
    wr(16'h0000, 8'hFF, "R11");
    rd(16'h4001, "R11");
    rd(16'hA002, "R11");
    rd(16'hC000, "R10");
    rd(16'h8000, "R10");
    wr(16'h9000, 8'h12, "R10");
    wr(16'h2000, 8'h02, "R10");
    rd(16'h4003, "R10");
    idle("R10");
    idle("R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule